// File: doc/BRIEF.md
# Power Event Interrupt Router

This block gathers power-management event pulses into sticky status bits and steers the enabled, pending ones onto one of two interrupt lines. One line is a legacy system-management interrupt. The other is a shareable system-control interrupt that the operating system sees. A mode bit selects the line: 0 selects legacy routing and 1 selects OS routing.

Software reaches the block over a small register bus. The bus is used to read the mode bit, handle status, set the enable mask and write a command port. In a dual-mode build, every command-port write latches a firmware event that always raises the system-management line. The firmware handler reads the written value, clears the event and flips the mode bit through a dedicated side path. The OS side only polls the mode bit.

An OS-only build ties the mode bit to 1 and drops the command port.

Top module: `pm_evt_router`

## Requirements
- R1: After reset in a dual-mode build, the mode bit (address 0, bit 0) reads 0, the status (address 1) and enable (address 2) registers read 0, and both `smi_irq` and `sci_irq` are low.
- R2: A high `evt_in[i]` at a clock edge sets status bit i. The bit stays set until software clears it.
- R3: Writing to address 1 clears each status bit whose write-data bit is 1 and leaves the others. If an event pulse and a clear hit the same bit in the same cycle, the bit stays set.
- R4: While the mode bit is 0, `smi_irq` is high when any status bit is set with its enable bit (address 2) set, and `sci_irq` stays low.
- R5: While the mode bit is 1, `sci_irq` is a level that is high exactly while any enabled status bit is set, and events do not drive `smi_irq`.
- R6: A status bit whose enable bit is 0 is still recorded but asserts neither output.
- R7: In a dual-mode build, a write to address 3 stores the low 8 bits, which read back at address 3. The write also sets the firmware-event bit (address 4, bit 0), and that bit raises `smi_irq` whatever the mode. Address 4 bit 1 reads 1 when the stored value equals the enter code (default 0xE1). Bit 2 reads 1 when it equals the leave code (default 0xE2).
- R8: Writing 1 to address 4 bit 0 clears the firmware-event bit. Writing 0 there leaves it set.
- R9: A pulse on `fw_mode_we` loads `fw_mode_val` into the mode bit at that edge. Bus writes to address 0 do not change it. Pending status moves to the newly selected output with no status bit lost.
- R10: In an OS-only build, the mode bit always reads 1, `fw_mode_we` is ignored, command-port writes raise nothing, and address 4 reads 0.
- R11: A read strobe (`rd_en`) at an edge loads `rd_data` with the addressed register as it stood before that edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | DW (16) | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW (16) | Registered read data |
| evt_in | input | NUM_EVT (8) | Event pulses, one per source |
| fw_mode_we | input | 1 | Firmware mode-bit write strobe |
| fw_mode_val | input | 1 | Firmware mode-bit value |
| smi_irq | output | 1 | Legacy system-management interrupt level |
| sci_irq | output | 1 | Shareable system-control interrupt level |

## Verification
Every state change lands at the rising edge that samples the stimulus: an event pulse, a bus write or a firmware mode write. Because the interrupt outputs are decoded directly from those registers, the new level is due in the same clock period after that edge. Read data appears one edge after the read strobe. The bench drives every input on the falling edge and samples outputs on the next falling edge, half a period after the edge that made the change. Reads always follow the write they check by at least one full cycle.

// File: rtl/pm_evt_pkg.sv
// Package: register addresses and shared constants of the power event router.
// Assumes a 3-bit register address space.
package pm_evt_pkg;
    localparam int          REG_AW  = 3;
    localparam logic [2:0]  A_CTL   = 3'd0;
    localparam logic [2:0]  A_STS   = 3'd1;
    localparam logic [2:0]  A_EN    = 3'd2;
    localparam logic [2:0]  A_CMD   = 3'd3;
    localparam logic [2:0]  A_FW    = 3'd4;
endpackage

// File: rtl/pm_evt_bank.sv
// Module: sticky event status bits with write-1-to-clear and an enable mask.
// Assumes one-cycle event pulses; a set wins over a clear in the same cycle.
module pm_evt_bank #(
    parameter int NUM_EVT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               sts_clr_we,
    input  logic               en_we,
    input  logic [NUM_EVT-1:0] wdata,
    output logic [NUM_EVT-1:0] sts_q,
    output logic [NUM_EVT-1:0] en_q
);
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
        // Status bit: event sets it, write-1 clears it, set has priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sts_q[i] <= 1'b0;
            else if (evt_in[i])
                sts_q[i] <= 1'b1;
            else if (sts_clr_we && wdata[i])
                sts_q[i] <= 1'b0;
        end

        // Enable bit: plain read/write mask.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en_q[i] <= 1'b0;
            else if (en_we)
                en_q[i] <= wdata[i];
        end
    end
endmodule

// File: rtl/pm_mode_ctl.sv
// Module: mode bit, command port and firmware-event flag.
// Assumes the firmware side owns the mode bit; bus writes never touch it.
// An OS-only build ties the mode to 1 and removes the command port.
module pm_mode_ctl #(
    parameter bit                DUAL_MODE = 1'b1,
    parameter int                CMD_W     = 8,
    parameter logic [CMD_W-1:0]  CMD_ENTER = 8'hE1,
    parameter logic [CMD_W-1:0]  CMD_LEAVE = 8'hE2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fw_mode_we,
    input  logic             fw_mode_val,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_wdata,
    input  logic             fw_clr_we,
    input  logic             fw_clr_bit,
    output logic             mode_q,
    output logic [CMD_W-1:0] cmd_last,
    output logic             cmd_pend,
    output logic             cmd_is_enter,
    output logic             cmd_is_leave
);
    if (DUAL_MODE) begin : g_dual
        logic             mode_r;
        logic [CMD_W-1:0] last_r;
        logic             pend_r;

        // Mode bit: loaded only by the firmware side path.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mode_r <= 1'b0;
            else if (fw_mode_we)
                mode_r <= fw_mode_val;
        end

        // Command value: holds the last write to the command port.
        always_ff @(posedge clk) begin
            if (!rst_n)
                last_r <= '0;
            else if (cmd_we)
                last_r <= cmd_wdata;
        end

        // Firmware event: set by any command write, cleared by write-1.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_r <= 1'b0;
            else if (cmd_we)
                pend_r <= 1'b1;
            else if (fw_clr_we && fw_clr_bit)
                pend_r <= 1'b0;
        end

        assign mode_q       = mode_r;
        assign cmd_last     = last_r;
        assign cmd_pend     = pend_r;
        assign cmd_is_enter = (last_r == CMD_ENTER);
        assign cmd_is_leave = (last_r == CMD_LEAVE);
    end else begin : g_os_only
        logic unused_in;
        assign unused_in    = ^{clk, rst_n, fw_mode_we, fw_mode_val, cmd_we,
                                cmd_wdata, fw_clr_we, fw_clr_bit};
        assign mode_q       = 1'b1;
        assign cmd_last     = '0;
        assign cmd_pend     = 1'b0;
        assign cmd_is_enter = 1'b0;
        assign cmd_is_leave = 1'b0;
    end
endmodule

// File: rtl/pm_irq_steer.sv
// Module: steers pending enabled status to the selected interrupt line.
// Assumes the firmware event always goes to the legacy line.
module pm_irq_steer #(
    parameter int NUM_EVT = 8
) (
    input  logic               mode,
    input  logic [NUM_EVT-1:0] sts,
    input  logic [NUM_EVT-1:0] en,
    input  logic               cmd_pend,
    output logic               smi_irq,
    output logic               sci_irq
);
    logic any_pending;

    // Routing: one pending level, split by mode, plus the firmware event.
    always_comb begin
        any_pending = |(sts & en);
        smi_irq     = (any_pending && !mode) || cmd_pend;
        sci_irq     = any_pending && mode;
    end
endmodule

// File: rtl/pm_evt_router.sv
// Module: top of the power event router; bus decode, read-back, routing.
// Assumes single-cycle write strobes and a registered read with one-edge latency.
module pm_evt_router
    import pm_evt_pkg::*;
#(
    parameter int               NUM_EVT   = 8,
    parameter int               DW        = 16,
    parameter bit               DUAL_MODE = 1'b1,
    parameter logic [7:0]       CMD_ENTER = 8'hE1,
    parameter logic [7:0]       CMD_LEAVE = 8'hE2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REG_AW-1:0]  addr,
    input  logic               wr_en,
    input  logic [DW-1:0]      wdata,
    input  logic               rd_en,
    output logic [DW-1:0]      rd_data,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               fw_mode_we,
    input  logic               fw_mode_val,
    output logic               smi_irq,
    output logic               sci_irq
);
    localparam int CMD_W = 8;

    logic               sts_clr_we, en_we, cmd_we, fw_clr_we;
    logic [NUM_EVT-1:0] sts_q, en_q;
    logic               mode_q, cmd_pend, cmd_is_enter, cmd_is_leave;
    logic [CMD_W-1:0]   cmd_last;
    logic [DW-1:0]      rd_next;

    // Write decode: one strobe per writable register.
    always_comb begin
        sts_clr_we = wr_en && (addr == A_STS);
        en_we      = wr_en && (addr == A_EN);
        cmd_we     = wr_en && (addr == A_CMD);
        fw_clr_we  = wr_en && (addr == A_FW);
    end

    pm_evt_bank #(.NUM_EVT(NUM_EVT)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_in     (evt_in),
        .sts_clr_we (sts_clr_we),
        .en_we      (en_we),
        .wdata      (wdata[NUM_EVT-1:0]),
        .sts_q      (sts_q),
        .en_q       (en_q)
    );

    pm_mode_ctl #(
        .DUAL_MODE (DUAL_MODE),
        .CMD_W     (CMD_W),
        .CMD_ENTER (CMD_ENTER),
        .CMD_LEAVE (CMD_LEAVE)
    ) u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .fw_mode_we   (fw_mode_we),
        .fw_mode_val  (fw_mode_val),
        .cmd_we       (cmd_we),
        .cmd_wdata    (wdata[CMD_W-1:0]),
        .fw_clr_we    (fw_clr_we),
        .fw_clr_bit   (wdata[0]),
        .mode_q       (mode_q),
        .cmd_last     (cmd_last),
        .cmd_pend     (cmd_pend),
        .cmd_is_enter (cmd_is_enter),
        .cmd_is_leave (cmd_is_leave)
    );

    pm_irq_steer #(.NUM_EVT(NUM_EVT)) u_steer (
        .mode     (mode_q),
        .sts      (sts_q),
        .en       (en_q),
        .cmd_pend (cmd_pend),
        .smi_irq  (smi_irq),
        .sci_irq  (sci_irq)
    );

    // Read mux: addressed register, zero-extended; unmapped reads 0.
    always_comb begin
        rd_next = '0;
        case (addr)
            A_CTL:   rd_next[0]           = mode_q;
            A_STS:   rd_next[NUM_EVT-1:0] = sts_q;
            A_EN:    rd_next[NUM_EVT-1:0] = en_q;
            A_CMD:   rd_next[CMD_W-1:0]   = cmd_last;
            A_FW:    rd_next[2:0]         = {cmd_is_leave, cmd_is_enter, cmd_pend};
            default: rd_next              = '0;
        endcase
    end

    // Read register: captures the mux on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_next;
    end
endmodule

// File: rtl/pm_evt_router_chk.sv
// Module: assertion checker bound into pm_evt_router.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module pm_evt_router_chk
    import pm_evt_pkg::*;
#(
    parameter int NUM_EVT = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [REG_AW-1:0]  addr,
    input logic               fw_mode_we,
    input logic               mode_q,
    input logic [NUM_EVT-1:0] sts_q,
    input logic               cmd_pend,
    input logic               smi_irq,
    input logic               sci_irq
);
    // R5
    sci_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sci_irq |-> mode_q);

    // R7
    cmd_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pend |-> smi_irq);

    // R2
    sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_STS) |=> (($past(sts_q) & ~sts_q) == '0));

    // R8
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pend && !(wr_en && addr == A_FW)) |=> cmd_pend);

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fw_mode_we |=> $stable(mode_q));
endmodule

bind pm_evt_router pm_evt_router_chk #(.NUM_EVT(NUM_EVT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .fw_mode_we (fw_mode_we),
    .mode_q     (mode_q),
    .sts_q      (sts_q),
    .cmd_pend   (cmd_pend),
    .smi_irq    (smi_irq),
    .sci_irq    (sci_irq)
);

// File: tb/sim_pm_evt_router.sv
// Bench: directed scenarios for the power event router, dual-mode (u0)
// and OS-only (u1) builds sharing the same stimulus.
module sim_pm_evt_router;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic          rd_en = 1'b0;
    logic [NE-1:0] evt_in = '0;
    logic          fw_mode_we = 1'b0;
    logic          fw_mode_val = 1'b0;
    logic [DW-1:0] rd0, rd1;
    logic          smi0, sci0, smi1, sci1;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_evt_router u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rd_data(rd0), .evt_in(evt_in), .fw_mode_we(fw_mode_we),
        .fw_mode_val(fw_mode_val), .smi_irq(smi0), .sci_irq(sci0)
    );

    pm_evt_router #(.DUAL_MODE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rd_data(rd1), .evt_in(evt_in), .fw_mode_we(fw_mode_we),
        .fw_mode_val(fw_mode_val), .smi_irq(smi1), .sci_irq(sci1)
    );

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [DW-1:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_evt(input logic [NE-1:0] e);
        evt_in = e;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic fw_mode(input logic v);
        fw_mode_we = 1'b1; fw_mode_val = v;
        @(negedge clk);
        fw_mode_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "smi after reset", {15'd0, smi0}, 16'd0);
        check("R1", "sci after reset", {15'd0, sci0}, 16'd0);
        bus_read(3'd0); check("R1", "mode bit", rd0, 16'd0);
        check("R10", "os-only mode bit", rd1, 16'd1);
        bus_read(3'd1); check("R1", "status", rd0, 16'd0);
        bus_read(3'd2); check("R1", "enable", rd0, 16'd0);
    endtask

    task automatic t_legacy_route();
        bus_write(3'd2, 16'h0001);
        pulse_evt(8'h01);
        check("R4", "smi on enabled event", {15'd0, smi0}, 16'd1);
        check("R4", "sci low in legacy", {15'd0, sci0}, 16'd0);
        check("R10", "os-only sci on event", {15'd0, sci1}, 16'd1);
        check("R10", "os-only smi low", {15'd0, smi1}, 16'd0);
        @(negedge clk);
        bus_read(3'd1); check("R2", "status sticky", rd0, 16'h0001);
        bus_write(3'd1, 16'h0001);
        check("R3", "smi after clear", {15'd0, smi0}, 16'd0);
        bus_read(3'd1); check("R3", "status cleared", rd0, 16'h0000);
    endtask

    task automatic t_mask();
        pulse_evt(8'h08);
        check("R6", "masked event smi", {15'd0, smi0}, 16'd0);
        bus_read(3'd1); check("R6", "masked event recorded", rd0, 16'h0008);
        bus_write(3'd1, 16'h0000);
        bus_read(3'd1); check("R3", "write zero keeps status", rd0, 16'h0008);
        bus_write(3'd1, 16'h0008);
        bus_read(3'd1); check("R3", "write one clears", rd0, 16'h0000);
    endtask

    task automatic t_set_wins();
        evt_in = 8'h01;
        bus_write(3'd1, 16'h0001);
        evt_in = '0;
        bus_read(3'd1); check("R3", "set wins over clear", rd0, 16'h0001);
        check("R3", "smi stays", {15'd0, smi0}, 16'd1);
    endtask

    task automatic t_mode_switch();
        fw_mode(1'b1);
        check("R9", "smi off after switch", {15'd0, smi0}, 16'd0);
        check("R5", "sci rerouted", {15'd0, sci0}, 16'd1);
        bus_write(3'd0, 16'h0000);
        bus_read(3'd0); check("R9", "bus write keeps mode", rd0, 16'd1);
        bus_read(3'd1); check("R9", "status kept", rd0, 16'h0001);
        pulse_evt(8'h02);
        check("R5", "sci stays with extra event", {15'd0, sci0}, 16'd1);
        bus_write(3'd1, 16'h0001);
        check("R5", "sci low when none enabled", {15'd0, sci0}, 16'd0);
        check("R5", "smi low in os mode", {15'd0, smi0}, 16'd0);
        bus_write(3'd1, 16'h0002);
    endtask

    task automatic t_cmd_port();
        bus_write(3'd3, 16'h00E1);
        check("R7", "cmd raises smi in os mode", {15'd0, smi0}, 16'd1);
        check("R7", "sci unaffected", {15'd0, sci0}, 16'd0);
        check("R10", "os-only ignores cmd", {15'd0, smi1}, 16'd0);
        bus_read(3'd3); check("R7", "cmd value", rd0, 16'h00E1);
        bus_read(3'd4); check("R7", "fw status enter", rd0, 16'h0003);
        check("R10", "os-only fw status", rd1, 16'h0000);
        bus_write(3'd4, 16'h0000);
        bus_read(3'd4); check("R8", "write zero keeps event", rd0, 16'h0003);
        bus_write(3'd4, 16'h0001);
        check("R8", "smi after clear", {15'd0, smi0}, 16'd0);
        bus_read(3'd4); check("R8", "event cleared", rd0, 16'h0002);
        bus_write(3'd3, 16'h00E2);
        bus_read(3'd4); check("R7", "fw status leave", rd0, 16'h0005);
        bus_write(3'd4, 16'h0001);
        fw_mode(1'b0);
        bus_read(3'd0); check("R9", "back to legacy", rd0, 16'd0);
        check("R10", "os-only ignores fw write", rd1, 16'd1);
        bus_read(3'd7); check("R11", "unmapped read", rd0, 16'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_legacy_route();
        t_mask();
        t_set_wins();
        t_mode_switch();
        t_cmd_port();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule